// File: doc/BRIEF.md
# Trace Sample Packer

This block sits between a processor's trace port and a capture memory. Every cycle in which the trace port presents a sample, the block formats it into a lane. A lane holds a 3-bit pipeline status, a packet field and a sync flag. The block then places the lane into a 32-bit word. The configured port width sets the packet size, the lane size and the number of lanes per word. A completed word leaves the block as a single-cycle valid pulse with its data.

A trigger is carried inside the data, with no extra bit. On a trigger sample the status field carries a fixed trigger code, and the sample's real status moves into the low three bits of the packet field.

A flush request pushes out a word that is only partly filled. A pending flag shows that lanes are held and not yet emitted. When the width select changes, any partial word is dropped. Port-mode combinations that the capture path cannot take are refused, and their samples are dropped.

Top module: `trace_packer`

## Requirements
- R1: After reset, `word_valid_o` is 0, `word_data_o` is 0 and `pending_o` is 0.
- R2: With width select 0 (4-bit port), three samples fill a word in 8-bit lanes at bits 0, 8 and 16, filled in arrival order. A lane holds the status in [2:0], packet bits [3:0] in [6:3] and sync in [7]. Word bits [31:24] are 0.
- R3: With width select 1 (8-bit port), two samples fill a word in 12-bit lanes at bits 0 and 12. A lane holds the status in [2:0], packet bits [7:0] in [10:3] and sync in [11]. Word bits [31:24] are 0.
- R4: With width select 2 (16-bit port), every accepted sample forms its own word. The status is in [2:0], the packet in [18:3] and sync in [19]. Bits [31:20] are 0.
- R5: `word_valid_o` is high for exactly the one cycle after the clock edge that accepts the last lane of a word, or after the edge of a flush. At all other times `word_data_o` is 0.
- R6: For a sample with `smp_trig_i` high, the status field holds `TRIG_CODE` (default 3'b110). The packet field's low three bits hold the sample's status, and the packet's higher bits are kept.
- R7: A flush emits the held lanes with the empty lanes zero. A sample presented in the same cycle is placed first and included. A flush with no lanes held and no sample emits nothing.
- R8: `pending_o` is high exactly while at least one lane is held and not yet emitted.
- R9: A cycle whose width select differs from the previous cycle's value discards the held lanes. A sample presented in that cycle starts a new word under the new width.
- R10: The accepted combinations are mode select 0 (normal) with width 0, 1 or 2, and mode select 1 (demultiplexed) with width 1 only. Mode 2 (multiplexed), mode 3, width 3 and demultiplexed mode with any width other than 1 are refused. A refused sample fills no lane and produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Trace sample present this cycle |
| smp_stat_i | input | 3 | Pipeline status of the sample |
| smp_pkt_i | input | 16 | Packet value; the low 4, 8 or 16 bits are used, depending on width |
| smp_sync_i | input | 1 | Sync flag of the sample |
| smp_trig_i | input | 1 | Sample is a trigger cycle |
| width_sel_i | input | 2 | Port width: 0 = 4-bit, 1 = 8-bit, 2 = 16-bit, 3 = reserved |
| mode_sel_i | input | 2 | Port mode: 0 = normal, 1 = demultiplexed, 2 = multiplexed, 3 = reserved |
| flush_i | input | 1 | Emit the partial word |
| word_valid_o | output | 1 | Packed word valid (one-cycle pulse) |
| word_data_o | output | 32 | Packed word |
| pending_o | output | 1 | Lanes held and not yet emitted |

## Verification
A wrong lane counter shows at the ports in one of two ways. `pending_o` can disagree on the very next cycle, or a word can be emitted one sample early or late. A wrong lane offset or field position corrupts the next emitted word, at most three samples later. Width-change and refused-mode faults show when a stale lane appears in the next word, or when a word appears where none is due. The reference model compares valid, data and pending on every cycle, including long random runs that mix widths, triggers and flushes.

// File: rtl/tp_pkg.sv
package tp_pkg;
    localparam int WORD_W   = 32;
    localparam int STAT_W   = 3;
    localparam int PKT_W    = 16;
    localparam int LANE_MAX = STAT_W + PKT_W + 1;
    localparam int NUM_WID  = 3;
    localparam int CNT_W    = 2;
    localparam int OFF_W    = 6;

    typedef enum logic [1:0] {
        W_P4  = 2'd0,
        W_P8  = 2'd1,
        W_P16 = 2'd2,
        W_RSV = 2'd3
    } width_e;

    typedef enum logic [1:0] {
        M_NORMAL = 2'd0,
        M_DEMUX  = 2'd1,
        M_MUX    = 2'd2,
        M_RSV    = 2'd3
    } mode_e;

    function automatic int pkt_bits(input int idx);
        return (idx == 0) ? 4 : (idx == 1) ? 8 : 16;
    endfunction

    function automatic int lanes_of(input int idx);
        return (idx == 0) ? 3 : (idx == 1) ? 2 : 1;
    endfunction

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] word;
        logic [1:0]        width;
        logic              out_v;
        logic [WORD_W-1:0] out_d;
    } pk_state_t;
endpackage

// File: rtl/tp_cfg_check.sv
module tp_cfg_check
    import tp_pkg::*;
(
    input  logic [1:0]       width_sel,
    input  logic [1:0]       mode_sel,
    output logic             cfg_ok,
    output logic [CNT_W-1:0] lanes,
    output logic [4:0]       lane_bits
);
    always_comb begin
        cfg_ok = 1'b0;
        case (mode_sel)
            M_NORMAL: cfg_ok = (width_sel != W_RSV);
            M_DEMUX:  cfg_ok = (width_sel == W_P8);
            default:  cfg_ok = 1'b0;
        endcase
    end

    always_comb begin
        case (width_sel)
            W_P4: begin
                lanes     = CNT_W'(lanes_of(0));
                lane_bits = 5'(STAT_W + pkt_bits(0) + 1);
            end
            W_P8: begin
                lanes     = CNT_W'(lanes_of(1));
                lane_bits = 5'(STAT_W + pkt_bits(1) + 1);
            end
            default: begin
                lanes     = CNT_W'(lanes_of(2));
                lane_bits = 5'(STAT_W + pkt_bits(2) + 1);
            end
        endcase
    end
endmodule

// File: rtl/tp_lane_fmt.sv
module tp_lane_fmt
    import tp_pkg::*;
#(
    parameter int          PW        = 8,
    parameter logic [2:0]  TRIG_CODE = 3'b110
) (
    input  logic [STAT_W-1:0]   stat,
    input  logic [PKT_W-1:0]    pkt,
    input  logic                sync,
    input  logic                trig,
    output logic [LANE_MAX-1:0] lane
);
    logic [PKT_W-1:0] eff_pkt;

    always_comb begin
        eff_pkt = trig ? {pkt[PKT_W-1:STAT_W], stat} : pkt;
        lane = '0;
        lane[STAT_W-1:0]   = trig ? TRIG_CODE : stat;
        lane[STAT_W +: PW] = eff_pkt[PW-1:0];
        lane[STAT_W + PW]  = sync;
    end
endmodule

// File: rtl/trace_packer.sv
module trace_packer
    import tp_pkg::*;
#(
    parameter logic [2:0] TRIG_CODE = 3'b110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid_i,
    input  logic [2:0]        smp_stat_i,
    input  logic [15:0]       smp_pkt_i,
    input  logic              smp_sync_i,
    input  logic              smp_trig_i,
    input  logic [1:0]        width_sel_i,
    input  logic [1:0]        mode_sel_i,
    input  logic              flush_i,
    output logic              word_valid_o,
    output logic [31:0]       word_data_o,
    output logic              pending_o
);
    logic [LANE_MAX-1:0] fmt_lane [NUM_WID];
    logic                cfg_ok;
    logic [CNT_W-1:0]    lanes;
    logic [4:0]          lane_bits;

    for (genvar g = 0; g < NUM_WID; g++) begin : g_fmt
        tp_lane_fmt #(
            .PW        (pkt_bits(g)),
            .TRIG_CODE (TRIG_CODE)
        ) u_fmt (
            .stat (smp_stat_i),
            .pkt  (smp_pkt_i),
            .sync (smp_sync_i),
            .trig (smp_trig_i),
            .lane (fmt_lane[g])
        );
    end

    tp_cfg_check u_cfg (
        .width_sel (width_sel_i),
        .mode_sel  (mode_sel_i),
        .cfg_ok    (cfg_ok),
        .lanes     (lanes),
        .lane_bits (lane_bits)
    );

    pk_state_t st_q, st_d;

    always_comb begin
        logic                width_chg;
        logic [CNT_W-1:0]    base_cnt;
        logic [WORD_W-1:0]   base_word;
        logic [LANE_MAX-1:0] sel_lane;
        logic [OFF_W-1:0]    off;
        logic [CNT_W-1:0]    cnt_n;
        logic [WORD_W-1:0]   word_n;
        logic                take;
        logic                emit;

        st_d      = st_q;
        width_chg = (width_sel_i != st_q.width);
        base_cnt  = width_chg ? '0 : st_q.cnt;
        base_word = width_chg ? '0 : st_q.word;

        case (width_sel_i)
            W_P4:    sel_lane = fmt_lane[0];
            W_P8:    sel_lane = fmt_lane[1];
            W_P16:   sel_lane = fmt_lane[2];
            default: sel_lane = '0;
        endcase

        take   = smp_valid_i && cfg_ok;
        off    = OFF_W'(base_cnt) * OFF_W'(lane_bits);
        cnt_n  = base_cnt;
        word_n = base_word;
        if (take) begin
            word_n = base_word | (WORD_W'(sel_lane) << off);
            cnt_n  = base_cnt + 1'b1;
        end

        emit = (take && (cnt_n == lanes)) || (flush_i && (cnt_n != '0));

        st_d.width = width_sel_i;
        st_d.out_v = emit;
        st_d.out_d = emit ? word_n : '0;
        st_d.cnt   = emit ? '0 : cnt_n;
        st_d.word  = emit ? '0 : word_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_valid_o = st_q.out_v;
    assign word_data_o  = st_q.out_d;
    assign pending_o    = (st_q.cnt != '0);
endmodule

// File: rtl/trace_packer_chk.sv
module trace_packer_chk #(
    parameter logic [2:0] TRIG_CODE = 3'b110
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_valid_i,
    input  logic [2:0]  smp_stat_i,
    input  logic [15:0] smp_pkt_i,
    input  logic        smp_sync_i,
    input  logic        smp_trig_i,
    input  logic [1:0]  width_sel_i,
    input  logic [1:0]  mode_sel_i,
    input  logic        flush_i,
    input  logic        word_valid_o,
    input  logic [31:0] word_data_o,
    input  logic        pending_o
);
    // R2 / R3: upper byte of a packed word stays clear for 4- and 8-bit ports
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && $past(width_sel_i) != 2'd2) |-> (word_data_o[31:24] == 8'h00));

    // R4: a legal 16-bit sample yields a word on the next cycle
    a_r4_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && width_sel_i == 2'd2 && mode_sel_i == 2'd0) |=> word_valid_o);

    // R6: trigger code in status, real status in packet low bits
    a_r6_trig_encode: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && smp_trig_i && width_sel_i == 2'd2 && mode_sel_i == 2'd0)
        |=> (word_data_o[2:0] == TRIG_CODE && word_data_o[5:3] == $past(smp_stat_i)));

    // R7 / R8: nothing held after an emit; idle flush with nothing held is silent
    a_r8_clear_on_emit: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> !pending_o);

    a_r7_empty_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && !pending_o && !smp_valid_i) |=> !word_valid_o);

    // R10: multiplexed mode samples are dropped
    a_r10_mux_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel_i == 2'd2 && smp_valid_i && !flush_i && !pending_o)
        |=> (!word_valid_o && !pending_o));

    // R5: data is zero outside a valid pulse
    a_r5_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid_o |-> (word_data_o == 32'h0));
endmodule

bind trace_packer trace_packer_chk #(.TRIG_CODE(TRIG_CODE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_valid_i  (smp_valid_i),
    .smp_stat_i   (smp_stat_i),
    .smp_pkt_i    (smp_pkt_i),
    .smp_sync_i   (smp_sync_i),
    .smp_trig_i   (smp_trig_i),
    .width_sel_i  (width_sel_i),
    .mode_sel_i   (mode_sel_i),
    .flush_i      (flush_i),
    .word_valid_o (word_valid_o),
    .word_data_o  (word_data_o),
    .pending_o    (pending_o)
);

// File: tb/trace_packer_test.sv
module trace_packer_test;
    localparam logic [2:0] TRIG = 3'b110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid_i = 1'b0;
    logic [2:0]  smp_stat_i = '0;
    logic [15:0] smp_pkt_i = '0;
    logic        smp_sync_i = 1'b0;
    logic        smp_trig_i = 1'b0;
    logic [1:0]  width_sel_i = '0;
    logic [1:0]  mode_sel_i = '0;
    logic        flush_i = 1'b0;
    logic        word_valid_o;
    logic [31:0] word_data_o;
    logic        pending_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int unsigned q[$];
    int          prev_width = 0;
    logic        exp_v = 1'b0;
    logic [31:0] exp_d = '0;
    logic        exp_p = 1'b0;

    always #10 clk = ~clk;

    trace_packer #(.TRIG_CODE(TRIG)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_valid_i  (smp_valid_i),
        .smp_stat_i   (smp_stat_i),
        .smp_pkt_i    (smp_pkt_i),
        .smp_sync_i   (smp_sync_i),
        .smp_trig_i   (smp_trig_i),
        .width_sel_i  (width_sel_i),
        .mode_sel_i   (mode_sel_i),
        .flush_i      (flush_i),
        .word_valid_o (word_valid_o),
        .word_data_o  (word_data_o),
        .pending_o    (pending_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural reference: one accepted clock edge
    task automatic model_edge();
        int w = int'(width_sel_i);
        int m = int'(mode_sel_i);
        bit legal = (m == 0 && w < 3) || (m == 1 && w == 1);
        int pw = (w == 0) ? 4 : (w == 1) ? 8 : 16;
        int nl = (w == 0) ? 3 : (w == 1) ? 2 : 1;
        int lw = pw + 4;
        if (w != prev_width) q.delete();
        prev_width = w;
        if (smp_valid_i && legal) begin
            int unsigned st = smp_trig_i ? int'(TRIG) : int'(smp_stat_i);
            int unsigned pk = smp_pkt_i;
            int unsigned ln;
            if (smp_trig_i) pk = (pk & 32'hFFF8) | smp_stat_i;
            pk = pk & ((1 << pw) - 1);
            ln = st | (pk << 3) | (int'(smp_sync_i) << (3 + pw));
            q.push_back(ln);
        end
        if (q.size() == nl || (flush_i && q.size() > 0)) begin
            int unsigned wd = 0;
            foreach (q[i]) wd = wd | (q[i] << (i * lw));
            exp_v = 1'b1;
            exp_d = wd;
            q.delete();
        end else begin
            exp_v = 1'b0;
            exp_d = '0;
        end
        exp_p = (q.size() > 0);
    endtask

    task automatic step(input string tag, input bit v, input logic [2:0] s,
                        input logic [15:0] p, input bit sy, input bit tr, input bit fl);
        smp_valid_i = v;
        smp_stat_i  = s;
        smp_pkt_i   = p;
        smp_sync_i  = sy;
        smp_trig_i  = tr;
        flush_i     = fl;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, "valid", 32'(word_valid_o), 32'(exp_v));
        check(tag, "data", word_data_o, exp_d);
        check(tag, "pending", 32'(pending_o), 32'(exp_p));
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 3'd0, 16'h0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "valid", 32'(word_valid_o), 32'h0);
        check("R1", "data", word_data_o, 32'h0);
        check("R1", "pending", 32'(pending_o), 32'h0);
        rst_n = 1'b1;
        idle("R1");

        // R4: 16-bit port, one sample per word
        width_sel_i = 2'd2; mode_sel_i = 2'd0;
        step("R4", 1, 3'd5, 16'hBEEF, 1, 0, 0);
        step("R4", 1, 3'd2, 16'h1234, 0, 0, 0);
        step("R6", 1, 3'd3, 16'hFFFF, 1, 1, 0);
        idle("R4");

        // R2: 4-bit port, three lanes
        width_sel_i = 2'd0;
        step("R2", 1, 3'd1, 16'hFFFA, 1, 0, 0);
        step("R8", 1, 3'd7, 16'h0005, 0, 0, 0);
        step("R2", 1, 3'd4, 16'h000C, 1, 0, 0);
        step("R6", 1, 3'd2, 16'h0009, 0, 1, 0);
        step("R5", 0, 3'd0, 16'h0, 0, 0, 0);
        step("R5", 1, 3'd6, 16'h0003, 1, 0, 0);
        step("R2", 1, 3'd0, 16'h000F, 1, 0, 0);

        // R3: 8-bit port in demultiplexed mode
        width_sel_i = 2'd1; mode_sel_i = 2'd1;
        step("R3", 1, 3'd3, 16'hA5C3, 1, 0, 0);
        step("R3", 1, 3'd6, 16'h0081, 0, 1, 0);

        // R7: flush of a partial word, with and without a sample
        step("R7", 1, 3'd5, 16'h0077, 1, 0, 0);
        step("R7", 0, 3'd0, 16'h0, 0, 0, 1);
        step("R7", 0, 3'd0, 16'h0, 0, 0, 1);
        step("R7", 1, 3'd1, 16'h0010, 0, 0, 1);
        mode_sel_i = 2'd0; width_sel_i = 2'd0;
        step("R7", 1, 3'd2, 16'h0001, 0, 0, 0);
        step("R7", 1, 3'd3, 16'h0002, 1, 0, 1);

        // R9: width change drops the partial word
        step("R9", 1, 3'd4, 16'h0006, 1, 0, 0);
        step("R9", 1, 3'd5, 16'h0007, 0, 0, 0);
        width_sel_i = 2'd1;
        step("R9", 1, 3'd1, 16'h0033, 0, 0, 0);
        step("R9", 1, 3'd2, 16'h0044, 1, 0, 0);
        step("R9", 1, 3'd3, 16'h0055, 0, 0, 0);
        width_sel_i = 2'd2;
        step("R9", 0, 3'd0, 16'h0, 0, 0, 1);

        // R10: refused combinations
        mode_sel_i = 2'd2; width_sel_i = 2'd1;
        step("R10", 1, 3'd7, 16'h00FF, 1, 0, 0);
        step("R10", 1, 3'd7, 16'h00FF, 1, 0, 1);
        mode_sel_i = 2'd1; width_sel_i = 2'd0;
        step("R10", 1, 3'd1, 16'h000F, 1, 0, 0);
        mode_sel_i = 2'd1; width_sel_i = 2'd2;
        step("R10", 1, 3'd1, 16'h000F, 1, 0, 0);
        mode_sel_i = 2'd0; width_sel_i = 2'd3;
        step("R10", 1, 3'd1, 16'h000F, 1, 0, 0);
        mode_sel_i = 2'd3; width_sel_i = 2'd1;
        step("R10", 1, 3'd1, 16'h000F, 1, 0, 0);
        mode_sel_i = 2'd0;
        step("R10", 1, 3'd2, 16'h0011, 0, 0, 0);
        mode_sel_i = 2'd2;
        step("R10", 1, 3'd2, 16'h0022, 0, 0, 0);
        mode_sel_i = 2'd0;
        step("R10", 0, 3'd0, 16'h0, 0, 0, 1);

        // R5: random mix of widths, modes, triggers and flushes
        for (int n = 0; n < 600; n++) begin
            if (($urandom % 16) == 0) width_sel_i = 2'($urandom % 3);
            if (($urandom % 20) == 0) mode_sel_i = 2'($urandom % 4);
            else if (($urandom % 6) == 0) mode_sel_i = 2'd0;
            step("R5", ($urandom % 4) != 0, 3'($urandom), 16'($urandom),
                 1'($urandom), ($urandom % 5) == 0, ($urandom % 9) == 0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule